// File: doc/BRIEF.md
# Start-of-Frame Coset Delineation FSM

This block locates frame boundaries in a stream of cells whose cell boundaries are already known. The first cell of every frame carries an extra HEC coset, the polynomial x^6+x^4+x^2+1 (8'h55). The block recomputes the header CRC for each cell. It then checks whether the received HEC carries that start-of-frame coset. From the result it runs a hunt, presync and sync state machine. The entry threshold (sigma) and the loss threshold (mu) are set on input pins.

A separate flag tells the block whether the standard coset is already applied to every HEC. In that case the first cell of a frame has the coset applied twice, so its HEC equals the raw CRC. The frame length in cells is a parameter. Once a candidate boundary has been found, only the cell expected to open each frame is examined. The machine runs only while the cell-delineation flag is high; when that flag drops, the machine returns to hunt.

The suggested configuration after reset is sigma = 8 and mu = 7.

Top module: `sof_frame_delin`

## Requirements
- R1: After reset, frame_sync and sof_pulse are 0 and the machine is in hunt, so any cell is examined.
- R2: A cell's HEC is start-of-frame correct when cell_hec equals CRC8(cell_hdr) XOR 8'h55 while coset_all is 0, and equals the raw CRC8(cell_hdr) while coset_all is 1. CRC8 uses the generator x^8+x^2+x+1 with zero initial value, and cell_hdr is taken MSB first (bit 31 first).
- R3: In hunt, the first examined cell with a correct start-of-frame HEC moves the machine to presync and becomes frame position 0.
- R4: Outside hunt, only cells at frame positions that are multiples of FRAME_CELLS are examined. Every other cell has no effect on sof_pulse or on the state.
- R5: In presync, sigma consecutive correct examined cells move the machine to sync, and frame_sync is high from the clock after the sigma-th. One errored examined cell returns the machine to hunt.
- R6: In sync, mu consecutive errored examined cells return the machine to hunt (frame_sync low). A correct examined cell clears the error run.
- R7: While cell_sync is 0 the machine is held in hunt. frame_sync is 0 from the following clock, and cell_start is ignored.
- R8: sof_pulse is high for exactly the one clock after a cell_start edge whose cell was examined and had a correct start-of-frame HEC.
- R9: A sigma_thr or mu_thr value of 0 acts as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cell_start | input | 1 | One-cycle strobe: header and HEC of a new cell are valid |
| cell_hdr | input | 32 | Four received header bytes, first byte in bits 31:24 |
| cell_hec | input | 8 | Received HEC byte |
| cell_sync | input | 1 | Cell delineation is in sync |
| coset_all | input | 1 | Standard coset is applied to every HEC |
| sigma_thr | input | CW | Consecutive correct start cells needed in presync |
| mu_thr | input | CW | Consecutive errored start cells that declare loss in sync |
| frame_sync | output | 1 | Frame delineation achieved |
| sof_pulse | output | 1 | Examined start-of-frame cell was correct |

## Verification
A wrong frame position shows up within one frame as a sof_pulse on the wrong cell, or as a missing pulse on the right one. A wrong run counter shows up as frame_sync rising or falling one examined start cell too early or too late, so the fault is visible within sigma or mu frames. A wrong coset rule suppresses every pulse in hunt at once. A missed cell-sync drop leaves frame_sync high one clock after the drop.

// File: rtl/sofd_pkg.sv
package sofd_pkg;
  typedef enum logic [1:0] {
    ST_HUNT    = 2'd0,
    ST_PRESYNC = 2'd1,
    ST_SYNC    = 2'd2
  } fstate_t;

  localparam logic [7:0] SOF_COSET = 8'h55;

  // Bit-serial CRC-8, generator x^8+x^2+x+1, zero seed, MSB first
  function automatic logic [7:0] hec_crc8(input logic [31:0] hdr);
    logic [7:0] r;
    logic       fb;
    r = 8'h00;
    for (int i = 31; i >= 0; i--) begin
      fb = r[7] ^ hdr[i];
      r  = {r[6:0], 1'b0};
      if (fb) r = r ^ 8'h07;
    end
    return r;
  endfunction

  // HEC a start-of-frame cell must carry
  function automatic logic [7:0] sof_hec(input logic [31:0] hdr, input logic coset_all);
    return hec_crc8(hdr) ^ (coset_all ? 8'h00 : SOF_COSET);
  endfunction
endpackage

// File: rtl/sofd_hec_check.sv
module sofd_hec_check
  import sofd_pkg::*;
(
  input  logic [31:0] hdr,
  input  logic [7:0]  hec,
  input  logic        coset_all,
  output logic        sof_match
);
  always_comb sof_match = (hec == sof_hec(hdr, coset_all));
endmodule

// File: rtl/sofd_slot_ctr.sv
module sofd_slot_ctr #(
  parameter int FRAME_CELLS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic adv,
  input  logic restart,
  output logic first_slot
);
  localparam int PW = (FRAME_CELLS > 1) ? $clog2(FRAME_CELLS) : 1;
  localparam logic [PW-1:0] LAST = PW'(FRAME_CELLS - 1);
  localparam logic [PW-1:0] AFTER_START = (FRAME_CELLS > 1) ? PW'(1) : '0;

  logic [PW-1:0] pos;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      pos <= '0;
    end else if (adv) begin
      if (restart)          pos <= AFTER_START;
      else if (pos == LAST) pos <= '0;
      else                  pos <= pos + 1'b1;
    end
  end

  assign first_slot = (pos == '0);
endmodule

// File: rtl/sofd_fsm.sv
module sofd_fsm
  import sofd_pkg::*;
#(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cell_sync,
  input  logic          ev_hit,
  input  logic          ev_miss,
  input  logic [CW-1:0] sigma_thr,
  input  logic [CW-1:0] mu_thr,
  output fstate_t       state,
  output logic          frame_sync
);
  function automatic logic [CW:0] eff_thr(input logic [CW-1:0] t);
    return (t == '0) ? (CW+1)'(1) : {1'b0, t};
  endfunction

  logic [CW-1:0] run;
  logic [CW:0]   run_next;

  assign run_next = {1'b0, run} + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n || !cell_sync) begin
      state <= ST_HUNT;
      run   <= '0;
    end else begin
      case (state)
        ST_HUNT: if (ev_hit) begin
          state <= ST_PRESYNC;
          run   <= '0;
        end
        ST_PRESYNC: begin
          if (ev_miss) begin
            state <= ST_HUNT;
            run   <= '0;
          end else if (ev_hit) begin
            if (run_next >= eff_thr(sigma_thr)) begin
              state <= ST_SYNC;
              run   <= '0;
            end else begin
              run <= run_next[CW-1:0];
            end
          end
        end
        ST_SYNC: begin
          if (ev_hit) begin
            run <= '0;
          end else if (ev_miss) begin
            if (run_next >= eff_thr(mu_thr)) begin
              state <= ST_HUNT;
              run   <= '0;
            end else begin
              run <= run_next[CW-1:0];
            end
          end
        end
        default: begin
          state <= ST_HUNT;
          run   <= '0;
        end
      endcase
    end
  end

  assign frame_sync = (state == ST_SYNC);
endmodule

// File: rtl/sof_frame_delin.sv
module sof_frame_delin
  import sofd_pkg::*;
#(
  parameter int FRAME_CELLS = 8,
  parameter int CW          = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cell_start,
  input  logic [31:0]   cell_hdr,
  input  logic [7:0]    cell_hec,
  input  logic          cell_sync,
  input  logic          coset_all,
  input  logic [CW-1:0] sigma_thr,
  input  logic [CW-1:0] mu_thr,
  output logic          frame_sync,
  output logic          sof_pulse
);
  fstate_t state;
  logic    sof_match;
  logic    first_slot;
  logic    in_hunt;
  logic    cell_adv;
  logic    examined;
  logic    ev_hit;
  logic    ev_miss;

  assign in_hunt  = (state == ST_HUNT);
  assign cell_adv = cell_start && cell_sync;
  assign examined = cell_adv && (in_hunt || first_slot);
  assign ev_hit   = examined && sof_match;
  assign ev_miss  = examined && !sof_match;

  sofd_hec_check u_hec (
    .hdr       (cell_hdr),
    .hec       (cell_hec),
    .coset_all (coset_all),
    .sof_match (sof_match)
  );

  sofd_slot_ctr #(.FRAME_CELLS(FRAME_CELLS)) u_slot (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (!cell_sync),
    .adv        (cell_adv),
    .restart    (in_hunt && ev_hit),
    .first_slot (first_slot)
  );

  sofd_fsm #(.CW(CW)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .cell_sync  (cell_sync),
    .ev_hit     (ev_hit),
    .ev_miss    (ev_miss),
    .sigma_thr  (sigma_thr),
    .mu_thr     (mu_thr),
    .state      (state),
    .frame_sync (frame_sync)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) sof_pulse <= 1'b0;
    else        sof_pulse <= ev_hit;
  end
endmodule

// File: rtl/sofd_checker.sv
module sofd_checker (
  input logic clk,
  input logic rst_n,
  input logic cell_start,
  input logic cell_sync,
  input logic frame_sync,
  input logic sof_pulse,
  input logic in_hunt,
  input logic first_slot,
  input logic ev_hit,
  input logic ev_miss
);
  assert_drop_to_hunt_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !cell_sync |=> !frame_sync);

  assert_sync_entry_on_hit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_sync) |-> sof_pulse);

  assert_loss_on_miss_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(frame_sync) && $past(cell_sync)) |-> $past(ev_miss));

  assert_pulse_needs_cell_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sof_pulse |-> $past(cell_start && cell_sync));

  assert_off_slot_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cell_start && !in_hunt && !first_slot) |=> !sof_pulse);

  assert_hunt_hit_presync_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_hunt && ev_hit) |=> (!frame_sync && !in_hunt));
endmodule

bind sof_frame_delin sofd_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cell_start (cell_start),
  .cell_sync  (cell_sync),
  .frame_sync (frame_sync),
  .sof_pulse  (sof_pulse),
  .in_hunt    (in_hunt),
  .first_slot (first_slot),
  .ev_hit     (ev_hit),
  .ev_miss    (ev_miss)
);

// File: tb/tb_sof_frame_delin.sv
module tb_sof_frame_delin;
  localparam int CLK_PERIOD = 10;
  localparam int FC = 4;
  localparam int CW = 4;
  localparam int NV = 26;
  // entry: {kind[1:0], exp_pulse, exp_sync}; kind 0 normal, 1 SOF, 2 corrupt
  localparam logic [3:0] VEC [NV] = '{
    4'b00_0_0, 4'b01_1_0, 4'b00_0_0, 4'b01_0_0, 4'b00_0_0, 4'b01_1_0,
    4'b00_0_0, 4'b00_0_0, 4'b00_0_0, 4'b01_1_1, 4'b00_0_1, 4'b01_0_1,
    4'b00_0_1, 4'b10_0_1, 4'b00_0_1, 4'b00_0_1, 4'b00_0_1, 4'b01_1_1,
    4'b00_0_1, 4'b00_0_1, 4'b00_0_1, 4'b10_0_1, 4'b00_0_1, 4'b00_0_1,
    4'b00_0_1, 4'b10_0_0
  };

  logic clk = 0, rst_n = 0, cell_start = 0, cell_sync = 0, coset_all = 0;
  logic [31:0] cell_hdr = '0;
  logic [7:0] cell_hec = '0;
  logic [CW-1:0] sigma_thr = 4'd2, mu_thr = 4'd2;
  logic frame_sync, sof_pulse;
  int checks = 0, fails = 0, cyc = 0, seed = 1;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sof_frame_delin #(.FRAME_CELLS(FC), .CW(CW)) dut (
    .clk(clk), .rst_n(rst_n), .cell_start(cell_start), .cell_hdr(cell_hdr),
    .cell_hec(cell_hec), .cell_sync(cell_sync), .coset_all(coset_all),
    .sigma_thr(sigma_thr), .mu_thr(mu_thr), .frame_sync(frame_sync), .sof_pulse(sof_pulse)
  );

  // polynomial long division of hdr*x^8 by 0x107
  function automatic logic [7:0] ref_crc(input logic [31:0] h);
    logic [39:0] d;
    d = {h, 8'h00};
    for (int i = 39; i >= 8; i--)
      if (d[i]) d = d ^ (40'h107 << (i - 8));
    return d[7:0];
  endfunction

  task automatic check(input string req, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b (t=%0t)", req, got, exp, $time);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  // called at a negedge; returns at a negedge after one idle cycle
  task automatic send(input int kind, input logic ep, input logic es, input string req);
    logic [7:0] c, sofh, norm;
    seed = seed * 1103515245 + 12345;
    cell_hdr = 32'(seed);
    c    = ref_crc(cell_hdr);
    sofh = coset_all ? c : (c ^ 8'h55);
    norm = coset_all ? (c ^ 8'h55) : c;
    cell_hec = (kind == 1) ? sofh : (kind == 2) ? (sofh ^ 8'h01) : norm;
    cell_start = 1;
    @(negedge clk);
    cell_start = 0;
    check({req, " pulse"}, sof_pulse, ep);
    check({req, " sync"}, frame_sync, es);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected finish");
      report();
    end
  end

  initial begin
    cell_sync = 1;
    do_reset();
    check("R1 reset sync", frame_sync, 1'b0);
    check("R1 reset pulse", sof_pulse, 1'b0);

    // vector walk: sigma=2, mu=2, frame of 4 cells (R2 R3 R4 R5 R6 R8)
    for (int i = 0; i < NV; i++)
      send(int'(VEC[i][3:2]), VEC[i][1], VEC[i][0], $sformatf("R5/R6/R4 vec%0d", i));

    // R5: errored start cell in presync returns to hunt
    do_reset();
    send(1, 1, 0, "R3 hunt hit");
    repeat (3) send(0, 0, 0, "R4 mid cell");
    send(2, 0, 0, "R5 presync miss");
    send(0, 0, 0, "R5 back in hunt, normal");
    send(1, 1, 0, "R3 hunt hit after miss");

    // R2: coset on all cells, start cell HEC is raw CRC
    do_reset();
    coset_all = 1;
    send(0, 0, 0, "R2 coset_all normal cell");
    send(1, 1, 0, "R2 coset_all start cell");
    coset_all = 0;

    // R9: zero thresholds act as one
    do_reset();
    sigma_thr = 0; mu_thr = 0;
    send(1, 1, 0, "R9 hunt hit");
    repeat (3) send(0, 0, 0, "R9 mid");
    send(1, 1, 1, "R9 sigma0 sync");
    repeat (3) send(0, 0, 1, "R9 mid sync");
    send(2, 0, 0, "R9 mu0 loss");

    // R7: cell sync drop forces hunt and ignores cells
    do_reset();
    send(1, 1, 0, "R7 setup hit");
    repeat (3) send(0, 0, 0, "R7 mid");
    send(1, 1, 1, "R7 setup sync");
    cell_sync = 0;
    @(negedge clk);
    check("R7 sync lost", frame_sync, 1'b0);
    send(1, 0, 0, "R7 ignored cell");
    cell_sync = 1;
    send(1, 1, 0, "R7 hunt again");

    report();
  end
endmodule